// File: doc/BRIEF.md
# Serial Shift-Out GPIO Expander

This block drives a chain of external serial-in/parallel-out shift registers. It provides a serial data line, a shift clock and a latch strobe, and so extends a chip's output pins by 17 bits. Software writes a 32-bit word that holds the 17 output levels in its low bits, with bit 31 set to start a transfer. The block shifts the 17 bits out with the most significant bit first. It then gives one latch strobe and clears bit 31 by itself. Reading the word back shows the stored levels, and bit 31 acts as a busy flag.

A configuration write sets the shift-clock divisor, the clock-to-data delay, the latch convention of the external chip and a flash mode. The divisor is a 2-bit code. The delay is the number of system clocks by which a data change leads the rising shift-clock edge. In flash mode, each pulse on the tick input from the PWM generator bank reloads the chain with the live PWM levels of the 17 expander pins. The external outputs then follow those waveforms, and the stored software word is left alone.

Top module: `sipo_expander`

## Requirements
- R1: After reset, rd_word reads 0, and ser_clk, ser_dout and ser_latch are all 0.
- R2: A write to an idle block with wr_word[31]=1 stores wr_word[16:0] and starts a transfer. rd_word[31] reads 1 for exactly 18*N clocks, where N is the shift-clock period in system clocks, and rd_word[16:0] returns the stored bits.
- R3: A transfer produces exactly 17 rising ser_clk edges. At these edges ser_dout carries bits 16, 15, ..., 0 of the source word, in that order.
- R4: Divisor code c (0..3) gives N = 4<<c, so N is 4, 8, 16 or 32. In each bit period ser_clk is low for the first N/2 clocks and high for the last N/2 clocks.
- R5: When ser_dout changes during a transfer, it changes exactly D clocks before the next rising ser_clk edge, where D is the configured delay. ser_dout does not change while ser_clk is high.
- R6: After the 17th bit the latch strobe is active for exactly N clocks, and ser_clk stays low during that time. With latch mode 0 the strobe is active high and idles low. With latch mode 1 it is active low and idles high.
- R7: A data write made while a transfer is in progress is ignored. Both the stored bits and the ongoing transfer are unchanged.
- R8: A write to an idle block with wr_word[31]=0 only stores wr_word[16:0]. No shift clock is produced.
- R9: A configuration write is ignored entirely if the delay is 0 or greater than N/2 for the requested code, or if it arrives while a transfer is in progress.
- R10: With flash mode enabled and the block idle, a pwm_tick pulse starts a transfer of pwm_lvl[16:0], and rd_word[16:0] is left unchanged. A tick that arrives while a transfer is in progress is ignored.
- R11: After reset the divisor code is 3 (N = 32), the delay is 1, latch mode is 0 and flash mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Data word write strobe |
| wr_word | input | 32 | Data word: bit 31 start, bits 16..0 levels |
| rd_word | output | 32 | Bit 31 busy, bits 16..0 stored levels |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_div_code | input | 2 | Divisor code, N = 4<<code |
| cfg_dly | input | 5 | Clocks by which a data change leads the clock rise |
| cfg_latch_mode | input | 1 | 0: active-high strobe, 1: active-low strobe |
| cfg_flash_en | input | 1 | Take levels from the PWM bank on each tick |
| pwm_tick | input | 1 | Refresh pulse from the PWM generator bank |
| pwm_lvl | input | 17 | Current PWM levels of the expander pins |
| ser_dout | output | 1 | Serial data to the shift-register chain |
| ser_clk | output | 1 | Shift clock |
| ser_latch | output | 1 | Latch strobe |

## Verification
The hardest situation to reach is a set of competing requests in the middle of a transfer. The case combines a data write with the start flag, a configuration write and a flash tick, all arriving while a flash-mode transfer is running. The bench injects all three in one cycle, part way through the bit periods. It then checks three things: the captured serial word is still the PWM snapshot, the stored word is unchanged, and the next transfer still runs at the old divisor. The delay rule is checked by timing every ser_dout change against the following clock rise. Alternating bit patterns are used so that almost every bit produces a change.

// File: rtl/sipo_expander.sv
module sipo_expander #(
  parameter int NBITS = 17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_word,
  output logic [31:0] rd_word,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_div_code,
  input  logic [4:0]  cfg_dly,
  input  logic        cfg_latch_mode,
  input  logic        cfg_flash_en,
  input  logic        pwm_tick,
  input  logic [16:0] pwm_lvl,
  output logic        ser_dout,
  output logic        ser_clk,
  output logic        ser_latch
);
  localparam int BW = $clog2(NBITS + 1);
  localparam logic [BW-1:0] LATCH_IDX = BW'(NBITS);

  logic [NBITS-1:0] data_q, shw, sh_cur;
  logic [BW-1:0]    bit_q, bit_n;
  logic [5:0]       ph, ph_n, ncnt, half;
  logic [1:0]       div_q;
  logic [4:0]       dly_q;
  logic             mode_q, flash_q, busy, busy_n, sdo_q;
  logic             start_sw, start_fl, start, upd, cfg_ok;

  assign ncnt = 6'd4 << div_q;
  assign half = ncnt >> 1;

  assign start_sw = wr_en && wr_word[31] && !busy;
  assign start_fl = flash_q && pwm_tick && !busy && !start_sw;
  assign start    = start_sw || start_fl;
  assign cfg_ok   = cfg_wr && !busy && !start && (cfg_dly != 5'd0) &&
                    ({1'b0, cfg_dly} <= (6'd2 << cfg_div_code));

  always_comb begin
    ph_n   = ph;
    bit_n  = bit_q;
    busy_n = busy;
    sh_cur = shw;
    if (start) begin
      ph_n   = '0;
      bit_n  = '0;
      busy_n = 1'b1;
      sh_cur = start_sw ? wr_word[NBITS-1:0] : pwm_lvl[NBITS-1:0];
    end else if (busy) begin
      if (ph == ncnt - 6'd1) begin
        ph_n  = '0;
        bit_n = bit_q + 1'b1;
        if (bit_q == LATCH_IDX) busy_n = 1'b0;
      end else begin
        ph_n = ph + 6'd1;
      end
    end
  end

  assign upd = busy_n && (bit_n < LATCH_IDX) && (ph_n == half - {1'b0, dly_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      shw     <= '0;
      bit_q   <= '0;
      ph      <= '0;
      busy    <= 1'b0;
      sdo_q   <= 1'b0;
      div_q   <= 2'd3;
      dly_q   <= 5'd1;
      mode_q  <= 1'b0;
      flash_q <= 1'b0;
    end else begin
      ph    <= ph_n;
      bit_q <= bit_n;
      busy  <= busy_n;
      if (start_sw || (wr_en && !busy)) data_q <= wr_word[NBITS-1:0];
      if (upd) begin
        sdo_q <= sh_cur[NBITS-1];
        shw   <= sh_cur << 1;
      end else begin
        shw <= sh_cur;
      end
      if (cfg_ok) begin
        div_q   <= cfg_div_code;
        dly_q   <= cfg_dly;
        mode_q  <= cfg_latch_mode;
        flash_q <= cfg_flash_en;
      end
    end
  end

  assign rd_word   = {busy, {(31-NBITS){1'b0}}, data_q};
  assign ser_dout  = sdo_q;
  assign ser_clk   = busy && (bit_q < LATCH_IDX) && (ph >= half);
  assign ser_latch = (busy && (bit_q == LATCH_IDX)) ^ mode_q;

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk);
  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));
  // R2
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bit_q) == LATCH_IDX));
  // R7
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(data_q));
  // R9
  dly_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_q != 5'd0) && ({1'b0, dly_q} <= half));
endmodule

// File: tb/sipo_expander_tb_top.sv
`timescale 1ns/1ps
module sipo_expander_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wr_en, cfg_wr, cfg_latch_mode, cfg_flash_en, pwm_tick;
  logic [31:0] wr_word, rd_word;
  logic [1:0]  cfg_div_code;
  logic [4:0]  cfg_dly;
  logic [16:0] pwm_lvl;
  logic ser_dout, ser_clk, ser_latch;

  sipo_expander dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [16:0] cap;
  int rises, lw, bc, hiw, dbad, ovl;

  // vector: {div code[24:23], delay[22:18], latch mode[17], data[16:0]}
  localparam logic [24:0] VEC [5] = '{
    {2'd0, 5'd1,  1'b0, 17'h15555},
    {2'd1, 5'd4,  1'b1, 17'h0AAAA},
    {2'd2, 5'd8,  1'b0, 17'h15555},
    {2'd3, 5'd16, 1'b1, 17'h0AAAA},
    {2'd2, 5'd3,  1'b0, 17'h1C3A5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] c, input logic [4:0] d, input logic m, input logic f);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_div_code = c; cfg_dly = d; cfg_latch_mode = m; cfg_flash_en = f;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_word = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int dly, input logic mode, input int inj_at);
    logic ps, pd;
    int since;
    bit chg;
    cap = '0; rises = 0; lw = 0; bc = 0; hiw = 0; dbad = 0; ovl = 0;
    ps = ser_clk; pd = ser_dout; since = 0; chg = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (!rd_word[31]) break;
      bc++;
      since++;
      if (ser_dout != pd) begin chg = 1'b1; since = 0; end
      if (ser_clk && !ps) begin
        cap = {cap[15:0], ser_dout};
        rises++;
        if (chg && since != dly) dbad++;
        chg = 1'b0;
      end
      if (ser_clk) hiw++;
      if (ser_latch != mode) begin
        lw++;
        if (ser_clk) ovl++;
      end
      if (i == inj_at) begin
        wr_en = 1'b1; wr_word = 32'h8000_0F0F;
        cfg_wr = 1'b1; cfg_div_code = 2'd0; cfg_dly = 5'd1;
        pwm_tick = 1'b1;
      end else if (i == inj_at + 1) begin
        wr_en = 1'b0; cfg_wr = 1'b0; pwm_tick = 1'b0;
      end
      ps = ser_clk; pd = ser_dout;
      @(negedge clk);
    end
  endtask

  task automatic check_xfer(input int n, input logic [16:0] exp, input string tag);
    chk(bc == 18 * n, {tag, " R2 busy length"}, bc, 18 * n);
    chk(rises == 17 && cap == exp, {tag, " R3 serial word"}, cap, exp);
    chk(hiw == 17 * n / 2, {tag, " R4 clock high time"}, hiw, 17 * n / 2);
    chk(dbad == 0, {tag, " R5 data-to-clock delay"}, dbad, 0);
    chk(lw == n && ovl == 0, {tag, " R6 latch width"}, lw, n);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_word = '0; cfg_wr = 1'b0; cfg_div_code = '0;
    cfg_dly = '0; cfg_latch_mode = 1'b0; cfg_flash_en = 1'b0; pwm_tick = 1'b0; pwm_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_word == 32'h0, "R1 rd_word", rd_word, 0);
    chk({ser_clk, ser_dout, ser_latch} == 3'b000, "R1 serial pins", {ser_clk, ser_dout, ser_latch}, 0);

    // R11 defaults: N=32, delay 1, mode 0
    write_word(32'h8001_5555);
    chk(rd_word == 32'h8001_5555, "R2 busy and stored bits", rd_word, 32'h8001_5555);
    measure(1, 1'b0, -1);
    check_xfer(32, 17'h15555, "R11 default");
    chk(rd_word == 32'h0001_5555, "R2 flag cleared", rd_word, 32'h0001_5555);

    foreach (VEC[k]) begin
      set_cfg(VEC[k][24:23], VEC[k][22:18], VEC[k][17], 1'b0);
      chk(ser_latch == VEC[k][17], "R6 latch idle level", ser_latch, VEC[k][17]);
      write_word({15'h4000, VEC[k][16:0]});
      measure(int'(VEC[k][22:18]), VEC[k][17], -1);
      check_xfer(4 << VEC[k][24:23], VEC[k][16:0], "vector");
    end

    // R8 store only
    set_cfg(2'd0, 5'd2, 1'b0, 1'b0);
    write_word(32'h0000_1234);
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        if (ser_clk || rd_word[31]) hi++;
        @(negedge clk);
      end
      chk(hi == 0, "R8 no transfer", hi, 0);
    end
    chk(rd_word == 32'h0000_1234, "R8 stored bits", rd_word, 32'h0000_1234);

    // R9 illegal delays ignored (N=8 requested, half 4)
    set_cfg(2'd1, 5'd5, 1'b0, 1'b0);
    set_cfg(2'd2, 5'd0, 1'b0, 1'b0);
    write_word(32'h8000_00FF);
    measure(2, 1'b0, -1);
    chk(bc == 18 * 4, "R9 bad delay ignored", bc, 72);

    // R10 flash mode, with R7 and R9 injections mid-transfer
    set_cfg(2'd1, 5'd2, 1'b0, 1'b1);
    pwm_lvl = 17'h1F00F;
    @(negedge clk);
    pwm_tick = 1'b1;
    @(negedge clk);
    pwm_tick = 1'b0;
    measure(2, 1'b0, 37);
    check_xfer(8, 17'h1F00F, "R10 flash");
    chk(rd_word == 32'h0000_00FF, "R7 R10 stored bits kept", rd_word, 32'h0000_00FF);
    repeat (4) @(negedge clk);
    chk(rd_word[31] == 1'b0, "R10 tick while busy ignored", rd_word[31], 0);
    pwm_lvl = 17'h00C3C;
    pwm_tick = 1'b1;
    @(negedge clk);
    pwm_tick = 1'b0;
    measure(2, 1'b0, -1);
    chk(bc == 18 * 8, "R9 config write while busy ignored", bc, 144);
    chk(cap == 17'h00C3C, "R10 second snapshot", cap, 17'h00C3C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule